// File: doc/BRIEF.md
# Event Counter Bank

This block holds a set of general event counters and a smaller set of fixed-function counters, all of the same width. Each counter sees a one-bit increment pulse per clock from its event source. The general counters also see a small per-cycle event count that a threshold can be compared against. Privilege filtering is reduced to a single mode input that says whether the current cycle belongs to the OS or to user code.

Software reaches the bank through a simple register bus with a valid, a write strobe, an 8-bit address and 64-bit data. Reads answer in the same cycle and writes take effect at the next clock edge. The bus holds the per-counter event selects, one packed control register for the fixed counters, a global enable mask, a global overflow status with a separate write-one-to-clear register, and two write aliases for each general counter. A second, read-only port returns any counter's value from an encoded index. A one-cycle interrupt pulse reports rollovers of counters whose interrupt bit is set.

Top module: `pmc_bank`

## Requirements
- R1: After a clock with rst_n low, all counters, event selects, the fixed control register, the global enable and the global status read zero, and irq_o is low.
- R2: General counter i advances by one in a cycle only if all of these hold: bit 0 (enable) of its event select at 0x00+i is set; bit i of the global enable at 0x21 is set; the mode qualifier matches (select bit 1 counts when priv_os=1, select bit 2 counts when priv_os=0); and its increment input is high. In every other case it holds its value.
- R3: When the threshold field, bits [11:8] of an event select, is nonzero, the counter advances only in qualified cycles where its per-cycle event count is at least the threshold. The increment pulse is then ignored.
- R4: Fixed counter j is controlled by nibble [4j+3:4j] of 0x20: bit 0 counts when priv_os=1, bit 1 counts when priv_os=0, and bit 3 enables its interrupt. Its global enable and status bit is 32+j. A zero nibble stops it.
- R5: A rollover from all ones to zero caused by counting sets the counter's bit in the global status at 0x22 (bit i, or bit 32+j). Writing a one to that bit of 0x23 clears it. Writes to 0x22 are ignored, and 0x23 reads zero.
- R6: irq_o is high for exactly one cycle, the cycle after a rollover edge, and only when that counter's interrupt bit is set (event select bit 3 or nibble bit 3).
- R7: A write to the legacy alias 0x08+i stores the low 32 data bits sign-extended to 48 bits. A write to the full alias 0x10+i stores the low 48 bits. Both aliases read back the same stored value. Fixed counters are written at 0x18+j, keeping the low 48 bits.
- R8: A full alias write with any of data bits [63:48] set raises bus_err in that cycle and leaves the counter unchanged.
- R9: On the read port, rd_idx bit 30 selects the fixed counters and bits [29:0] select the counter. Bit 31 returns only the low 32 bits, zero-extended. An index that selects no counter raises rd_err and returns zero.
- R10: When a bus write and an increment hit the same counter in one cycle, the written value is stored. A value change made by a write never sets a status bit.
- R11: A counter preset to 2^48 + 1 - N reads 1 after exactly N counted events, and its status bit is set.
- R12: bus_err is raised for any access to an unmapped address: an event select or counter index beyond the implemented count, or a global register offset above 0x23. Event selects read back bits 0-3 and [11:8] as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| priv_os | input | 1 | Current cycle is OS mode (1) or user mode (0) |
| gp_ev_inc | input | NUM_GP | Per-cycle increment pulse of each general counter |
| gp_ev_cnt | input | NUM_GP*4 | Per-cycle event count of each general counter, for the threshold |
| fx_ev_inc | input | NUM_FX | Per-cycle increment pulse of each fixed counter |
| bus_valid | input | 1 | Register access valid |
| bus_write | input | 1 | Access is a write |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, same cycle |
| bus_err | output | 1 | Access rejected, same cycle |
| rd_idx | input | 32 | Encoded counter index for the read port |
| rd_data | output | 64 | Counter value for rd_idx |
| rd_err | output | 1 | rd_idx selects no counter |
| irq_o | output | 1 | Overflow interrupt pulse |

## Verification
The counting path is driven with sparse and dense increment pulses. These separate correct gating from a counter that runs freely or ignores the global mask, the mode qualifier or a zero fixed nibble. Ramped per-cycle event counts against a threshold show whether the threshold comparison or the pulse decides. Presets near all ones, on counters with and without interrupt enable, show whether the rollover timing, the status bit and the interrupt are tied to the right counter. A write that lands in the same cycle as an increment shows which one has priority. Both write aliases are fed values with the sign bit set, values with only high bits set and oversized values, to tell sign extension, truncation and rejection apart.

// File: rtl/pmc_pkg.sv
// Package pmc_pkg
// Shared constants and types of the event counter bank: register map
// regions, event-select field positions and the stored select layout.
// Assumes an 8-bit register address split into a 5-bit region and a
// 3-bit index.
package pmc_pkg;
    localparam int EV_W  = 4;          // per-cycle event count / threshold width
    localparam int SEL_W = 8 + EV_W;   // event-select readback width

    // address regions (bus_addr[7:3])
    localparam logic [4:0] RG_SEL  = 5'd0;
    localparam logic [4:0] RG_LEG  = 5'd1;
    localparam logic [4:0] RG_FULL = 5'd2;
    localparam logic [4:0] RG_FIX  = 5'd3;
    localparam logic [4:0] RG_GLB  = 5'd4;

    // offsets inside the global region
    localparam logic [2:0] GL_FXCTL = 3'd0;
    localparam logic [2:0] GL_EN    = 3'd1;
    localparam logic [2:0] GL_STAT  = 3'd2;
    localparam logic [2:0] GL_CLR   = 3'd3;

    // event-select bit positions on the bus
    localparam int SB_EN  = 0;
    localparam int SB_OS  = 1;
    localparam int SB_USR = 2;
    localparam int SB_INT = 3;
    localparam int SB_THR = 8;

    typedef struct packed {
        logic [EV_W-1:0] thr;
        logic            intr;
        logic            usr;
        logic            os;
        logic            en;
    } evsel_t;
endpackage

// File: rtl/pmc_qualify.sv
// Module pmc_qualify
// Decides, per cycle, whether one counter advances. The inputs are the
// local enable, the mode qualifiers, the global enable bit and the event
// inputs. A nonzero threshold replaces the increment pulse with a
// comparison of the per-cycle event count. Purely combinational; fixed
// counters tie the threshold to zero.
module pmc_qualify
    import pmc_pkg::*;
(
    input  logic            en_local,
    input  logic            os_q,
    input  logic            usr_q,
    input  logic [EV_W-1:0] thr,
    input  logic            priv_os,
    input  logic            gbl_en,
    input  logic            ev_inc,
    input  logic [EV_W-1:0] ev_cnt,
    output logic            tick
);
    logic mode_ok;
    logic evt;

    // combine qualifiers into the per-cycle advance decision
    always_comb begin
        mode_ok = priv_os ? os_q : usr_q;
        evt     = (thr != '0) ? (ev_cnt >= thr) : ev_inc;
        tick    = en_local && gbl_en && mode_ok && evt;
    end

    // guards on the advance decision
    always_comb begin
        // R3
        thr_gate_chk: assert (!(tick && (thr != '0) && (ev_cnt < thr)))
            else $error("advance below threshold");
        // R2
        gbl_gate_chk: assert (!(tick && !gbl_en))
            else $error("advance with global enable clear");
    end
endmodule

// File: rtl/pmc_counter.sv
// Module pmc_counter
// One W-bit event counter. A load has priority over an increment. The
// wrap output flags an increment that rolls the count from all ones to
// zero; a load never flags wrap.
module pmc_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         wrap
);
    logic [W-1:0] val_q;

    // rollover detection on a counted event
    always_comb wrap = inc && !ld && (&val_q);

    // count register: load first, then increment
    always_ff @(posedge clk) begin
        if (!rst_n)      val_q <= '0;
        else if (ld)     val_q <= ld_val;
        else if (inc)    val_q <= val_q + 1'b1;
    end

    assign val = val_q;

    // R7
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (val_q == $past(ld_val)));
    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (val_q == '0));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !inc) |=> $stable(val_q));
endmodule

// File: rtl/pmc_bank.sv
// Module pmc_bank
// Bank of NUM_GP general and NUM_FX fixed event counters behind a simple
// register bus, with global enable, overflow status, write-one-to-clear,
// an overflow interrupt pulse and an indexed read port. Bus reads and the
// read port are combinational; all state changes on the clock edge.
// Assumes FX_BASE > NUM_GP, NUM_GP and NUM_FX at most 8, CTR_W in 33..63.
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_GP  = 4,
    parameter int NUM_FX  = 3,
    parameter int CTR_W   = 48,
    parameter int FX_BASE = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   priv_os,
    input  logic [NUM_GP-1:0]      gp_ev_inc,
    input  logic [NUM_GP*EV_W-1:0] gp_ev_cnt,
    input  logic [NUM_FX-1:0]      fx_ev_inc,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [7:0]             bus_addr,
    input  logic [63:0]            bus_wdata,
    output logic [63:0]            bus_rdata,
    output logic                   bus_err,
    input  logic [31:0]            rd_idx,
    output logic [63:0]            rd_data,
    output logic                   rd_err
    ,
    output logic                   irq_o
);
    localparam int GBITS = FX_BASE + NUM_FX;
    localparam int FXC_W = 4 * NUM_FX;
    localparam logic [GBITS-1:0] IMPL =
        {{NUM_FX{1'b1}}, {(FX_BASE-NUM_GP){1'b0}}, {NUM_GP{1'b1}}};

    logic [4:0]       region;
    logic [2:0]       sub;
    logic             hit, fw_bad, wr_ok;
    logic [CTR_W-1:0] leg_val, full_val;

    logic [GBITS-1:0] gen_q, stat_q, clr_mask, wrap_g, int_g;
    logic [FXC_W-1:0] fxctl_q;
    logic             irq_q;

    logic [NUM_GP-1:0][CTR_W-1:0] gp_val;
    logic [NUM_GP-1:0][SEL_W-1:0] sel_view;
    logic [NUM_GP-1:0]            gp_wrap, gp_tick, gp_ld, gp_int;
    logic [NUM_FX-1:0][CTR_W-1:0] fx_val;
    logic [NUM_FX-1:0]            fx_wrap, fx_tick, fx_ld, fx_int;

    // address decode, full-alias range check and error response
    always_comb begin
        region = bus_addr[7:3];
        sub    = bus_addr[2:0];
        case (region)
            RG_SEL, RG_LEG, RG_FULL: hit = (int'(sub) < NUM_GP);
            RG_FIX:                  hit = (int'(sub) < NUM_FX);
            RG_GLB:                  hit = (sub <= GL_CLR);
            default:                 hit = 1'b0;
        endcase
        fw_bad   = bus_write && (region == RG_FULL) && (bus_wdata[63:CTR_W] != '0);
        bus_err  = bus_valid && (!hit || fw_bad);
        wr_ok    = bus_valid && bus_write && hit && !fw_bad;
        leg_val  = {{(CTR_W-32){bus_wdata[31]}}, bus_wdata[31:0]};
        full_val = bus_wdata[CTR_W-1:0];
    end

    // general counters with their event selects
    for (genvar g = 0; g < NUM_GP; g++) begin : g_gp
        evsel_t sel_r;

        // event-select register
        always_ff @(posedge clk) begin
            if (!rst_n)
                sel_r <= '0;
            else if (wr_ok && region == RG_SEL && sub == 3'(g))
                sel_r <= '{thr:  bus_wdata[SB_THR +: EV_W], intr: bus_wdata[SB_INT],
                           usr:  bus_wdata[SB_USR],         os:   bus_wdata[SB_OS],
                           en:   bus_wdata[SB_EN]};
        end

        assign gp_ld[g]    = wr_ok && (region == RG_LEG || region == RG_FULL) && sub == 3'(g);
        assign gp_int[g]   = sel_r.intr;
        assign sel_view[g] = {sel_r.thr, 4'b0000, sel_r.intr, sel_r.usr, sel_r.os, sel_r.en};

        pmc_qualify u_qual (
            .en_local (sel_r.en),
            .os_q     (sel_r.os),
            .usr_q    (sel_r.usr),
            .thr      (sel_r.thr),
            .priv_os  (priv_os),
            .gbl_en   (gen_q[g]),
            .ev_inc   (gp_ev_inc[g]),
            .ev_cnt   (gp_ev_cnt[g*EV_W +: EV_W]),
            .tick     (gp_tick[g])
        );

        pmc_counter #(.W(CTR_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (gp_ld[g]),
            .ld_val ((region == RG_LEG) ? leg_val : full_val),
            .inc    (gp_tick[g]),
            .val    (gp_val[g]),
            .wrap   (gp_wrap[g])
        );
    end

    // fixed counters controlled by nibbles of the packed control register
    for (genvar f = 0; f < NUM_FX; f++) begin : g_fx
        logic [3:0] nib;
        assign nib       = fxctl_q[4*f +: 4];
        assign fx_ld[f]  = wr_ok && region == RG_FIX && sub == 3'(f);
        assign fx_int[f] = nib[3];

        pmc_qualify u_qual (
            .en_local (|nib),
            .os_q     (nib[0]),
            .usr_q    (nib[1]),
            .thr      ('0),
            .priv_os  (priv_os),
            .gbl_en   (gen_q[FX_BASE+f]),
            .ev_inc   (fx_ev_inc[f]),
            .ev_cnt   ('0),
            .tick     (fx_tick[f])
        );

        pmc_counter #(.W(CTR_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (fx_ld[f]),
            .ld_val (full_val),
            .inc    (fx_tick[f]),
            .val    (fx_val[f]),
            .wrap   (fx_wrap[f])
        );
    end

    // map per-counter rollover and interrupt bits onto global bit positions
    always_comb begin
        wrap_g = '0;
        int_g  = '0;
        wrap_g[NUM_GP-1:0]       = gp_wrap;
        wrap_g[FX_BASE +: NUM_FX] = fx_wrap;
        int_g[NUM_GP-1:0]        = gp_int;
        int_g[FX_BASE +: NUM_FX]  = fx_int;
        clr_mask = (wr_ok && region == RG_GLB && sub == GL_CLR) ? bus_wdata[GBITS-1:0] : '0;
    end

    // global control, status and interrupt registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fxctl_q <= '0;
            gen_q   <= '0;
            stat_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (wr_ok && region == RG_GLB && sub == GL_FXCTL) fxctl_q <= bus_wdata[FXC_W-1:0];
            if (wr_ok && region == RG_GLB && sub == GL_EN)    gen_q   <= bus_wdata[GBITS-1:0] & IMPL;
            stat_q <= (stat_q & ~clr_mask) | wrap_g;
            irq_q  <= |(wrap_g & int_g);
        end
    end

    assign irq_o = irq_q;

    // bus read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write && hit) begin
            case (region)
                RG_SEL: for (int i = 0; i < NUM_GP; i++)
                            if (sub == 3'(i)) bus_rdata = 64'(sel_view[i]);
                RG_LEG, RG_FULL: for (int i = 0; i < NUM_GP; i++)
                            if (sub == 3'(i)) bus_rdata = 64'(gp_val[i]);
                RG_FIX: for (int i = 0; i < NUM_FX; i++)
                            if (sub == 3'(i)) bus_rdata = 64'(fx_val[i]);
                RG_GLB: case (sub)
                            GL_FXCTL: bus_rdata = 64'(fxctl_q);
                            GL_EN:    bus_rdata = 64'(gen_q);
                            GL_STAT:  bus_rdata = 64'(stat_q);
                            default:  bus_rdata = '0;
                        endcase
                default: bus_rdata = '0;
            endcase
        end
    end

    // indexed read port with fixed-select and low-half flags
    always_comb begin
        logic [63:0] raw;
        raw    = '0;
        rd_err = rd_idx[30] ? (rd_idx[29:0] >= 30'(NUM_FX)) : (rd_idx[29:0] >= 30'(NUM_GP));
        for (int i = 0; i < NUM_GP; i++)
            if (!rd_idx[30] && rd_idx[29:0] == 30'(i)) raw = 64'(gp_val[i]);
        for (int i = 0; i < NUM_FX; i++)
            if (rd_idx[30] && rd_idx[29:0] == 30'(i)) raw = 64'(fx_val[i]);
        rd_data = rd_idx[31] ? {32'b0, raw[31:0]} : raw;
    end

    // R5
    status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_g) |=> ((stat_q & $past(wrap_g)) == $past(wrap_g)));
    // R5
    status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask != '0) && (wrap_g == '0)) |=> ((stat_q & $past(clr_mask)) == '0));
    // R6
    irq_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (stat_q != '0));
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && (wrap_g == '0)) |=> !irq_q);
endmodule

// File: tb/pmc_bank_bench.sv
// Bench for pmc_bank: a behavioural model of the register map and the
// counters is stepped once per clock and compared on every clock (irq and
// a rotating read-port index), plus directed register reads.
module pmc_bank_bench;
    localparam int NG = 4;
    localparam int NF = 3;
    localparam int FXB = 32;
    localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;
    localparam logic [34:0] IMPLM = 35'h7_0000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_os = 1'b1;
    logic [NG-1:0]   gp_ev_inc = '0;
    logic [NG*4-1:0] gp_ev_cnt = '0;
    logic [NF-1:0]   fx_ev_inc = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_err;
    logic [31:0] rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        irq_o;

    always #4 clk = ~clk;

    pmc_bank u_pmc_bank (
        .clk(clk), .rst_n(rst_n), .priv_os(priv_os),
        .gp_ev_inc(gp_ev_inc), .gp_ev_cnt(gp_ev_cnt), .fx_ev_inc(fx_ev_inc),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err), .irq_o(irq_o)
    );

    // reference model state
    longint unsigned m_gp[NG];
    longint unsigned m_fx[NF];
    logic [11:0] m_sel[NG];
    logic [11:0] m_fxc;
    logic [34:0] m_gen, m_stat;
    logic        m_irq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0, rot = 0;
    bit auto_rd = 1'b1;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint unsigned sext32(input logic [63:0] d);
        return d[31] ? (64'h0000_FFFF_0000_0000 | 64'(d[31:0])) : 64'(d[31:0]);
    endfunction

    // one clock of the model, using the inputs held by the bench
    task automatic model_step();
        logic [34:0] wrapv, clr;
        logic        irqn, wr, mode_ok, ev;
        logic [3:0]  nib, thr;
        wrapv = '0; clr = '0; irqn = 1'b0;
        wr = bus_valid && bus_write;
        for (int i = 0; i < NG; i++) begin
            mode_ok = priv_os ? m_sel[i][1] : m_sel[i][2];
            thr = m_sel[i][11:8];
            ev  = (thr != 0) ? (gp_ev_cnt[4*i +: 4] >= thr) : gp_ev_inc[i];
            if (wr && bus_addr == 8'(8'h08 + i))
                m_gp[i] = sext32(bus_wdata);
            else if (wr && bus_addr == 8'(8'h10 + i) && bus_wdata[63:48] == 0)
                m_gp[i] = bus_wdata & MASK;
            else if (m_sel[i][0] && m_gen[i] && mode_ok && ev) begin
                if (m_gp[i] == MASK) begin
                    m_gp[i] = 0; wrapv[i] = 1'b1;
                    if (m_sel[i][3]) irqn = 1'b1;
                end else m_gp[i] = m_gp[i] + 1;
            end
        end
        for (int j = 0; j < NF; j++) begin
            nib = m_fxc[4*j +: 4];
            mode_ok = priv_os ? nib[0] : nib[1];
            if (wr && bus_addr == 8'(8'h18 + j))
                m_fx[j] = bus_wdata & MASK;
            else if (nib != 0 && m_gen[FXB+j] && mode_ok && fx_ev_inc[j]) begin
                if (m_fx[j] == MASK) begin
                    m_fx[j] = 0; wrapv[FXB+j] = 1'b1;
                    if (nib[3]) irqn = 1'b1;
                end else m_fx[j] = m_fx[j] + 1;
            end
        end
        if (wr) begin
            if (bus_addr < 8'h04) m_sel[bus_addr[1:0]] = bus_wdata[11:0] & 12'hF0F;
            if (bus_addr == 8'h20) m_fxc = bus_wdata[11:0];
            if (bus_addr == 8'h21) m_gen = bus_wdata[34:0] & IMPLM;
            if (bus_addr == 8'h23) clr = bus_wdata[34:0];
        end
        m_stat = (m_stat & ~clr) | wrapv;
        m_irq  = irqn;
    endtask

    function automatic logic [31:0] rot_idx(input int r);
        return (r < NG) ? 32'(r) : (32'h4000_0000 | 32'(r - NG));
    endfunction

    // advance one clock and compare the model on the following negedge
    task automatic tick();
        longint unsigned exp;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(irq_o == m_irq, "R6 irq pulse", 64'(irq_o), 64'(m_irq));
        if (irq_o) irq_cnt++;
        if (auto_rd) begin
            exp = (rot < NG) ? m_gp[rot] : m_fx[rot-NG];
            chk(rd_data == exp && !rd_err, "R2 per-clock counter value", rd_data, exp);
            rot = (rot + 1) % (NG + NF);
            rd_idx = rot_idx(rot);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr_err(input logic [7:0] a, input logic [63:0] d, input string tag);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        #1;
        chk(bus_err == 1'b1, tag, 64'(bus_err), 64'd1);
        tick();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input longint unsigned exp, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata == exp && !bus_err, tag, bus_rdata, exp);
        bus_valid = 1'b0;
    endtask

    task automatic rd_err_chk(input logic [7:0] a, input string tag);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        chk(bus_err == 1'b1, tag, 64'(bus_err), 64'd1);
        bus_valid = 1'b0;
    endtask

    task automatic port_chk(input logic [31:0] idx, input longint unsigned exp,
                            input bit exp_err, input string tag);
        rd_idx = idx;
        #1;
        chk(rd_data == exp && rd_err == exp_err, tag, rd_data, exp);
    endtask

    initial begin
        for (int i = 0; i < NG; i++) begin m_gp[i] = 0; m_sel[i] = '0; end
        for (int j = 0; j < NF; j++) m_fx[j] = 0;
        m_fxc = '0; m_gen = '0; m_stat = '0; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(irq_o == 1'b0, "R1 irq low", 64'(irq_o), 0);
        rd_chk(8'h08, 0, "R1 gp0 zero");
        rd_chk(8'h00, 0, "R1 select zero");
        rd_chk(8'h20, 0, "R1 fixed ctrl zero");
        rd_chk(8'h21, 0, "R1 global enable zero");
        rd_chk(8'h22, 0, "R1 status zero");

        // R2: gating by enable and mode
        wr(8'h21, 64'hF);
        wr(8'h00, 64'h3);
        wr(8'h01, 64'h5);
        for (int k = 0; k < 12; k++) begin
            gp_ev_inc = (k % 3 != 0) ? 4'b0011 : 4'b0010;
            tick();
        end
        gp_ev_inc = '0;
        rd_chk(8'h08, 8, "R2 sparse pulses counted");
        rd_chk(8'h09, 0, "R2 user-only counter idle in OS mode");
        priv_os = 1'b0; gp_ev_inc = 4'b0011;
        ticks(4);
        gp_ev_inc = '0; priv_os = 1'b1;
        rd_chk(8'h09, 4, "R2 user-only counter in user mode");
        rd_chk(8'h08, 8, "R2 OS-only counter idle in user mode");
        wr(8'h21, 64'hE);
        gp_ev_inc = 4'b0001;
        ticks(5);
        gp_ev_inc = '0;
        rd_chk(8'h08, 8, "R2 global enable clear blocks counting");
        wr(8'h21, 64'hF);

        // R3: threshold
        wr(8'h02, 64'h203);
        gp_ev_inc[2] = 1'b1;
        for (int k = 0; k < 8; k++) begin
            gp_ev_cnt[11:8] = 4'(k % 4);
            tick();
        end
        gp_ev_cnt = '0; gp_ev_inc = '0;
        rd_chk(8'h0A, 4, "R3 threshold 2 on ramp");
        rd_chk(8'h02, 64'h203, "R12 select readback");

        // R7 / R8: write aliases
        wr(8'h0B, 64'h0000_0000_8000_0005);
        rd_chk(8'h13, 64'h0000_FFFF_8000_0005, "R7 legacy sign-extends");
        wr(8'h0B, 64'hFFFF_FFFF_0000_0042);
        rd_chk(8'h0B, 64'h42, "R7 legacy takes low 32 bits");
        wr(8'h13, 64'h0000_1234_5678_9ABC);
        rd_chk(8'h0B, 64'h0000_1234_5678_9ABC, "R7 full alias read via legacy");
        wr_err(8'h13, 64'h0001_0000_0000_0000, "R8 oversized write error");
        rd_chk(8'h13, 64'h0000_1234_5678_9ABC, "R8 counter unchanged");

        // R11 / R6 / R5: preset overflow with interrupt
        wr(8'h03, 64'hB);
        wr(8'h13, 64'h0000_FFFF_FFFF_FFFC);
        irq_cnt = 0;
        gp_ev_inc = 4'b1000;
        ticks(5);
        gp_ev_inc = '0;
        tick();
        rd_chk(8'h13, 1, "R11 preset wraps to one");
        chk(irq_cnt == 1, "R6 one pulse with int bit", 64'(irq_cnt), 1);
        rd_chk(8'h22, 64'h8, "R5 status bit 3");
        wr(8'h08, 64'hFFFF_FFFF);
        gp_ev_inc = 4'b0001;
        tick();
        gp_ev_inc = '0;
        tick();
        rd_chk(8'h08, 0, "R5 counter wrapped");
        rd_chk(8'h22, 64'h9, "R5 status set without int bit");
        chk(irq_cnt == 1, "R6 no pulse without int bit", 64'(irq_cnt), 1);
        wr(8'h23, 64'h8);
        rd_chk(8'h22, 64'h1, "R5 write-one clears bit 3");
        wr(8'h22, 64'h0);
        rd_chk(8'h22, 64'h1, "R5 status write ignored");
        rd_chk(8'h23, 0, "R12 clear register reads zero");

        // R4: fixed counters
        wr(8'h21, 64'h2_0000_000F);
        wr(8'h20, 64'h90);
        wr(8'h19, 64'h0000_FFFF_FFFF_FFFF);
        irq_cnt = 0;
        fx_ev_inc = 3'b011;
        ticks(3);
        fx_ev_inc = '0;
        tick();
        rd_chk(8'h19, 2, "R4 fixed 1 counts past wrap");
        rd_chk(8'h18, 0, "R4 fixed 0 zero nibble idle");
        chk(irq_cnt == 1, "R4 fixed int bit pulse", 64'(irq_cnt), 1);
        rd_chk(8'h22, 64'h2_0000_0001, "R4 fixed status bit 33");
        wr(8'h21, 64'h3_0000_000F);
        wr(8'h20, 64'h2);
        fx_ev_inc = 3'b011;
        ticks(3);
        rd_chk(8'h18, 0, "R4 user-only fixed idle in OS mode");
        rd_chk(8'h19, 2, "R4 zero nibble stops");
        priv_os = 1'b0;
        ticks(2);
        fx_ev_inc = '0; priv_os = 1'b1;
        rd_chk(8'h18, 2, "R4 user-only fixed in user mode");

        // R9: read port encoding
        wr(8'h12, 64'h0000_ABCD_1234_5678);
        auto_rd = 1'b0;
        port_chk(32'h0000_0002, 64'h0000_ABCD_1234_5678, 1'b0, "R9 general full read");
        port_chk(32'h8000_0002, 64'h1234_5678, 1'b0, "R9 fast low 32 bits");
        port_chk(32'h4000_0001, 2, 1'b0, "R9 fixed select");
        port_chk(32'hC000_0000, 2, 1'b0, "R9 fixed fast");
        port_chk(32'h0000_0004, 0, 1'b1, "R9 general index out of range");
        port_chk(32'h4000_0003, 0, 1'b1, "R9 fixed index out of range");
        rd_idx = rot_idx(rot);
        auto_rd = 1'b1;

        // R10: write beats increment; write rollover sets no status
        wr(8'h23, 64'h7_FFFF_FFFF);
        wr(8'h08, 64'hFFFF_FFFF);
        gp_ev_inc = 4'b0001;
        wr(8'h10, 64'h7);
        gp_ev_inc = '0;
        rd_chk(8'h08, 7, "R10 write wins over increment");
        rd_chk(8'h22, 0, "R10 write causes no status");

        // R12: unmapped addresses
        rd_err_chk(8'h30, "R12 unmapped region");
        rd_err_chk(8'h1B, "R12 fixed index beyond count");
        rd_err_chk(8'h24, "R12 global offset beyond clear");
        wr_err(8'h05, 64'h1, "R12 select index beyond count");
        ticks(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule